// File: doc/BRIEF.md
# Timer-Linked Capture and Compare Unit

This block sits beside a free-running 16-bit timer and works in one of several modes. A 4-bit mode input selects the mode. In a capture mode it watches an input pin. When a qualifying edge arrives, it stores the current timer count in a capture register. In a compare mode it watches for the timer count to equal a programmed value. On that match it drives an output pin, raises an interrupt flag, or requests that the timer be reset.

The input pin is asynchronous and is brought into the clock domain through two flops. Edges are found on the synchronized signal. Captures can be thinned by a prescaler, so that only every 4th or every 16th rising edge is stored. The prescaler restarts from zero whenever the mode changes. The interrupt flag is sticky. Software clears it through a dedicated clear input.

Top module: `capcmp_unit`

## Requirements
- R1: After reset, and in any mode other than 0010, 0100, 0101, 0110, 0111, 1000, 1001, 1010 and 1011 (including 0000 and the reserved 0001), the unit is idle. pin_oe is 0, pin_out is 0, irq_flag is 0 one cycle later, evt_trig is 0, and the prescaler is cleared.
- R2: pin_in passes through two synchronizing flops before edge detection. A level change on pin_in at clock edge k is seen as an edge in the cycle after edge k+2. The capture register takes the timer value of that cycle at edge k+3.
- R3: Mode 0100 captures on every falling edge and mode 0101 captures on every rising edge. Each capture loads cap_val with tmr and sets irq_flag.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 captures on every 16th rising edge. The rising edges in between leave cap_val and irq_flag unchanged.
- R5: In a cycle where the mode differs from the previous cycle's mode, the prescaler is cleared and no capture or compare action takes place. The pin latch is loaded with 1 if the new mode is 1001 and with 0 otherwise.
- R6: Mode 0010 drives pin_oe high and inverts pin_out on each match. Each match also sets irq_flag.
- R7: Mode 1000 starts with pin_out low and sets it high on a match. Mode 1001 starts with pin_out high and clears it on a match. In both modes pin_oe is high and each match sets irq_flag.
- R8: Mode 1010 keeps pin_oe low and only sets irq_flag on a match.
- R9: Mode 1011 keeps pin_oe low. On a match it pulses evt_trig high for exactly one cycle, which asks the timer to reset, and it sets irq_flag.
- R10: Outside idle modes, irq_flag stays set until flag_clr is high at a clock edge. A set event in the same cycle takes priority over the clear.
- R11: A match is the first cycle in which tmr equals cmp_val after a cycle in which it did not. A timer that holds at the compare value produces only one action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Operating mode select |
| tmr | input | TW | Current timer count |
| cmp_val | input | TW | Compare value |
| pin_in | input | 1 | Asynchronous capture input pin |
| flag_clr | input | 1 | Clears irq_flag |
| pin_out | output | 1 | Compare output pin value |
| pin_oe | output | 1 | Output enable for the pin |
| cap_val | output | TW | Captured timer value |
| irq_flag | output | 1 | Sticky interrupt flag |
| evt_trig | output | 1 | One-cycle timer-reset request |

## Verification
The capture path is tried with isolated single edges, with bursts of rising edges whose count is chosen to fall just below and just on the 4 and 16 boundaries, and with a mode switch in the middle of a prescale count. Together these show whether captures happen on every edge, on the correct edge polarity, and whether the prescaler is correctly thinned and restarted. The compare path is tried with a timer that wraps through the compare value many times, and with a timer frozen at the compare value. These tell apart edge-qualified matches from level matches, and show whether the toggle, set, clear, flag-only and trigger actions each behave as specified. Flag clears are interleaved with set events to show the sticky behaviour and the set-over-clear priority.

// File: rtl/capcmp_unit.sv
module capcmp_unit #(
  parameter int TW = 16,
  parameter int PS_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] cmp_val,
  input  logic          pin_in,
  input  logic          flag_clr,
  output logic          pin_out,
  output logic          pin_oe,
  output logic [TW-1:0] cap_val,
  output logic          irq_flag,
  output logic          evt_trig
);
  localparam logic [3:0] M_TGL   = 4'b0010;
  localparam logic [3:0] M_FALL  = 4'b0100;
  localparam logic [3:0] M_RISE  = 4'b0101;
  localparam logic [3:0] M_RISE4 = 4'b0110;
  localparam logic [3:0] M_RISE16= 4'b0111;
  localparam logic [3:0] M_SET   = 4'b1000;
  localparam logic [3:0] M_CLR   = 4'b1001;
  localparam logic [3:0] M_IRQ   = 4'b1010;
  localparam logic [3:0] M_TRIG  = 4'b1011;
  localparam logic [PS_W-1:0] PS4_LAST  = PS_W'(3);
  localparam logic [PS_W-1:0] PS16_LAST = PS_W'(15);

  logic [2:0]      sync_q;
  logic [3:0]      mode_q;
  logic            match_q;
  logic [PS_W-1:0] pcnt;
  logic            pin_q;

  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire changed = mode != mode_q;
  wire match   = tmr == cmp_val;
  wire hit     = match & ~match_q & ~changed;

  logic active;
  always_comb begin
    case (mode)
      M_TGL, M_FALL, M_RISE, M_RISE4, M_RISE16,
      M_SET, M_CLR, M_IRQ, M_TRIG: active = 1'b1;
      default:                     active = 1'b0;
    endcase
  end

  logic ps_mode, ps_last;
  assign ps_mode = (mode == M_RISE4) | (mode == M_RISE16);
  assign ps_last = (mode == M_RISE4) ? (pcnt == PS4_LAST) : (pcnt == PS16_LAST);

  logic cap_ev;
  assign cap_ev = ~changed & (((mode == M_FALL) & fall) |
                              ((mode == M_RISE) & rise) |
                              (ps_mode & rise & ps_last));

  logic cmp_flag_mode;
  assign cmp_flag_mode = (mode == M_TGL) | (mode == M_SET) | (mode == M_CLR) |
                         (mode == M_IRQ) | (mode == M_TRIG);

  wire set_ev = cap_ev | (hit & cmp_flag_mode);

  assign pin_oe  = (mode == M_TGL) | (mode == M_SET) | (mode == M_CLR);
  assign pin_out = pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      mode_q  <= '0;
      match_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[1:0], pin_in};
      mode_q  <= mode;
      match_q <= match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (changed || !ps_mode)
      pcnt <= '0;
    else if (rise)
      pcnt <= ps_last ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pin_q <= 1'b0;
    else if (changed)
      pin_q <= (mode == M_CLR);
    else if (!active)
      pin_q <= 1'b0;
    else if (hit) begin
      case (mode)
        M_TGL:   pin_q <= ~pin_q;
        M_SET:   pin_q <= 1'b1;
        M_CLR:   pin_q <= 1'b0;
        default: pin_q <= pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cap_val <= '0;
    else if (cap_ev)
      cap_val <= tmr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      evt_trig <= 1'b0;
    end else begin
      irq_flag <= active & ((irq_flag & ~flag_clr) | set_ev);
      evt_trig <= hit & (mode == M_TRIG);
    end
  end
endmodule

// File: rtl/capcmp_unit_chk.sv
module capcmp_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          flag_clr,
  input logic          pin_out,
  input logic          pin_oe,
  input logic [TW-1:0] cap_val,
  input logic          irq_flag,
  input logic          evt_trig
);
  logic act;
  assign act = mode inside {4'b0010, 4'b0100, 4'b0101, 4'b0110, 4'b0111,
                            4'b1000, 4'b1001, 4'b1010, 4'b1011};

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (!irq_flag && !evt_trig && !pin_out));

  assert_cap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3] || mode == 4'b0010) |=> $stable(cap_val));

  assert_clr_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'b1001 && mode != $past(mode)) |=> pin_out);

  assert_irq_no_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'b1010) |-> !pin_oe);

  assert_trig_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trig |=> !evt_trig);

  assert_trig_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trig |-> irq_flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr && act) |=> irq_flag);
endmodule

bind capcmp_unit capcmp_unit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .flag_clr(flag_clr),
  .pin_out(pin_out), .pin_oe(pin_oe), .cap_val(cap_val),
  .irq_flag(irq_flag), .evt_trig(evt_trig)
);

// File: tb/capcmp_unit_bench.sv
module capcmp_unit_bench;
  localparam int TW = 16;
  localparam int WRAP = 39;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic [TW-1:0] tmr = '0, cmp_val = '0;
  logic pin_in = 1'b0, flag_clr = 1'b0;
  logic pin_out, pin_oe, irq_flag, evt_trig;
  logic [TW-1:0] cap_val;
  logic tmr_hold = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0, trig_seen = 0;

  capcmp_unit #(.TW(TW)) u_capcmp_unit (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tmr(tmr), .cmp_val(cmp_val),
    .pin_in(pin_in), .flag_clr(flag_clr), .pin_out(pin_out), .pin_oe(pin_oe),
    .cap_val(cap_val), .irq_flag(irq_flag), .evt_trig(evt_trig)
  );

  always #2ns clk = ~clk;

  // behavioural reference, advanced on each rising edge
  int s1 = 0, s2 = 0, s3 = 0, pmode = 0, pmatch = 0, pc = 0;
  int e_pin = 0, e_flag = 0, e_trig = 0, e_cap = 0;

  function automatic int is_active(int m);
    return (m == 2 || (m >= 4 && m <= 11 && m != 3)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; s3 = 0; pmode = 0; pmatch = 0; pc = 0;
      e_pin = 0; e_flag = 0; e_trig = 0; e_cap = 0;
    end else begin
      int m, r, f, ch, nm, setf, lim;
      m = int'(mode);
      r = (s2 == 1 && s3 == 0) ? 1 : 0;
      f = (s2 == 0 && s3 == 1) ? 1 : 0;
      ch = (m != pmode) ? 1 : 0;
      nm = (tmr == cmp_val && pmatch == 0) ? 1 : 0;
      pmatch = (tmr == cmp_val) ? 1 : 0;
      s3 = s2; s2 = s1; s1 = int'(pin_in);
      pmode = m;
      setf = 0; e_trig = 0;
      if (ch) begin
        pc = 0; e_pin = (m == 9) ? 1 : 0;
      end else if (!is_active(m)) begin
        pc = 0; e_pin = 0;
      end else begin
        if (m == 4 && f) begin e_cap = int'(tmr); setf = 1; end
        if (m == 5 && r) begin e_cap = int'(tmr); setf = 1; end
        if ((m == 6 || m == 7) && r) begin
          lim = (m == 6) ? 3 : 15;
          if (pc == lim) begin e_cap = int'(tmr); setf = 1; pc = 0; end
          else pc++;
        end
        if (m != 6 && m != 7) pc = 0;
        if (nm && m >= 8) setf = 1;
        if (nm && m == 2) begin e_pin = 1 - e_pin; setf = 1; end
        if (nm && m == 8) e_pin = 1;
        if (nm && m == 9) e_pin = 0;
        if (nm && m == 11) e_trig = 1;
      end
      if (!is_active(m)) e_flag = 0;
      else e_flag = ((e_flag && !flag_clr) || setf) ? 1 : 0;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // bench timer: wraps, and restarts when the trigger is seen
  always @(negedge clk) begin
    if (evt_trig) trig_seen++;
    if (!tmr_hold) tmr <= (evt_trig || tmr == TW'(WRAP)) ? '0 : tmr + 1'b1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2/R3/R4/R5 cap_val", int'(cap_val), e_cap);
      check("R6/R7/R5 pin_out", int'(pin_out), e_pin);
      check("R10/R3 irq_flag", int'(irq_flag), e_flag);
      check("R9 evt_trig", int'(evt_trig), e_trig);
      check("R1/R6/R8 pin_oe", int'(pin_oe),
            (mode == 4'b0010 || mode == 4'b1000 || mode == 4'b1001) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(int n, int gap);
    for (int i = 0; i < n; i++) begin
      pin_in = 1'b1; wait_cyc(gap);
      pin_in = 1'b0; wait_cyc(gap);
    end
  endtask

  task automatic set_mode(logic [3:0] m);
    mode = m; wait_cyc(2);
  endtask

  initial begin
    logic [TW-1:0] c0;
    logic p0;
    wait_cyc(4);
    check("R1 reset pin_oe", int'(pin_oe), 0);
    check("R1 reset irq_flag", int'(irq_flag), 0);
    check("R1 reset cap_val", int'(cap_val), 0);
    rst_n = 1'b1;
    wait_cyc(3);

    // R3: every rising edge, then every falling edge
    set_mode(4'b0101);
    edges(5, 3);
    edges(3, 7);
    check("R3 flag after rising captures", int'(irq_flag), 1);
    flag_clr = 1'b1; wait_cyc(1); flag_clr = 1'b0; wait_cyc(1);
    check("R10 flag cleared", int'(irq_flag), 0);
    set_mode(4'b0100);
    edges(4, 5);
    check("R3 flag after falling captures", int'(irq_flag), 1);
    flag_clr = 1'b1; edges(2, 2); flag_clr = 1'b0;
    wait_cyc(4);

    // R4: every 4th rising edge
    set_mode(4'b0110);
    flag_clr = 1'b1; wait_cyc(1); flag_clr = 1'b0;
    c0 = cap_val;
    edges(3, 3); wait_cyc(4);
    check("R4 no capture before 4th edge", int'(cap_val), int'(c0));
    check("R4 no flag before 4th edge", int'(irq_flag), 0);
    edges(1, 3); wait_cyc(4);
    check("R4 flag on 4th edge", int'(irq_flag), 1);
    edges(9, 2);

    // R4/R5: every 16th, with a switch mid-count
    set_mode(4'b0111);
    edges(10, 2);
    set_mode(4'b0110);
    flag_clr = 1'b1; wait_cyc(1); flag_clr = 1'b0;
    edges(3, 3); wait_cyc(4);
    check("R5 prescaler restarted after mode change", int'(irq_flag), 0);
    set_mode(4'b0111);
    edges(33, 2);
    wait_cyc(4);

    // R6/R11: toggle on match, frozen timer
    cmp_val = TW'(17);
    set_mode(4'b0010);
    wait_cyc(130);
    while (tmr != TW'(15)) wait_cyc(1);
    tmr_hold = 1'b1; tmr = TW'(17);
    p0 = pin_out;
    wait_cyc(8);
    check("R11 single toggle while timer held", int'(pin_out), int'(!p0));
    tmr_hold = 1'b0;
    wait_cyc(60);

    // R7: set and clear modes
    set_mode(4'b1000);
    wait_cyc(90);
    set_mode(4'b1001);
    check("R7 initial high", int'(pin_out), 1);
    wait_cyc(90);

    // R8: flag only
    set_mode(4'b1010);
    check("R8 output enable low", int'(pin_oe), 0);
    flag_clr = 1'b1; wait_cyc(1); flag_clr = 1'b0;
    wait_cyc(80);

    // R9: trigger
    cmp_val = TW'(9);
    trig_seen = 0;
    set_mode(4'b1011);
    wait_cyc(100);
    check("R9 triggers observed", (trig_seen >= 5) ? 1 : 0, 1);

    // R1: reserved and other idle codes
    set_mode(4'b0001);
    edges(4, 2);
    check("R1 reserved idle flag", int'(irq_flag), 0);
    set_mode(4'b1100);
    edges(4, 2);
    check("R1 unused code idle oe", int'(pin_oe), 0);
    set_mode(4'b0000);
    wait_cyc(5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule